// File: doc/BRIEF.md
# DDR Refresh Credit Scheduler

This block tells a DDR SDRAM command arbiter when to send AUTO REFRESH. A free-running interval timer adds one refresh credit for every refresh interval of clock cycles. The arbiter may hold refreshes back while it has other work, and the block stores up to `MAX_OWED` (eight by default) owed refreshes. Once the traffic clears, the arbiter can send them one after another.

The block shows its need for a refresh at two levels. A normal request asks for a refresh only when the arbiter reports that it is idle. An urgent request appears once the credit store is full, and it stands whether or not the arbiter is busy. The arbiter answers either request with a one-cycle issued pulse. The block then shows a refresh-active window of `RFC_CYCLES` cycles, and no other command may go to the device during that window. The controller must also keep the clock enable high for that window.

An issued pulse may arrive when there is nothing to issue: either no credit is owed or a refresh window is already open. The block ignores such a pulse and reports it on a one-cycle error output.

Top module: `refresh_credit_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_o`, `urgent_o`, `rfc_active_o` and `err_o` are all 0, and no credit is owed.
- R2: One credit is added every `TICK_CYCLES` clock cycles. With no issue and `busy_i` low, `req_o` first rises after exactly `TICK_CYCLES` rising edges following reset release.
- R3: Credits accumulate up to `MAX_OWED` and then saturate. After any longer wait, exactly `MAX_OWED` issues are accepted before `req_o` falls.
- R4: `req_o` is 1 only when at least one credit is owed and no refresh window is open. While fewer than `MAX_OWED` credits are owed, it also requires `busy_i` to be low. `busy_i` acts combinationally.
- R5: `urgent_o` is 1 exactly while `MAX_OWED` credits are owed. In that state `req_o` is 1 regardless of `busy_i`, unless a refresh window is open.
- R6: An accepted issue removes one credit. `rfc_active_o` then goes high at the next edge, stays high for exactly `RFC_CYCLES` cycles, and `req_o` stays low throughout.
- R7: An issue pulse that arrives while no credit is owed, or while `rfc_active_o` is high, changes no state. `err_o` is 1 for the single cycle that follows each such pulse.
- R8: If the arbiter issues whenever `urgent_o` is seen, the gap between accepted refreshes, and the gap from reset to the first refresh, never exceeds `MAX_OWED + 1` intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Arbiter has other commands pending |
| issued_i | input | 1 | One-cycle pulse: an AUTO REFRESH was sent |
| req_o | output | 1 | Refresh wanted now |
| urgent_o | output | 1 | Credit store full; refresh cannot wait |
| rfc_active_o | output | 1 | Refresh window open; block other commands |
| err_o | output | 1 | Previous cycle carried an ignored issue pulse |

## Verification
Some outputs change in the same cycle as their cause. `req_o` follows `busy_i` within that cycle, while `urgent_o` and the credit-driven part of `req_o` change one edge after the interval tick. The other outputs follow the edge that samples their cause. `rfc_active_o` rises one edge after the issue that opens the window and falls `RFC_CYCLES` edges later. `err_o` is high for the single cycle after the edge that sampled an ignored pulse. The bench applies both inputs on the falling edge and lets `busy_i` settle for a short delay. It then compares every output against a cycle-count model kept from the requirements, and only after that decides its issue pulse. Each comparison therefore sees the state left by the previous rising edge together with the current `busy_i`.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Urgency level derived from the owed-credit count
    typedef enum logic [1:0] {
        LVL_NONE   = 2'd0,
        LVL_NORMAL = 2'd1,
        LVL_URGENT = 2'd2
    } rfs_level_e;

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int TICK_CYCLES = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = wrap;

endmodule

// File: rtl/rfs_credit_ctr.sv
module rfs_credit_ctr
    import rfs_pkg::*;
#(
    parameter int MAX_OWED = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       take_i,
    output rfs_level_e level_o
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

    typedef struct packed {
        logic [OW-1:0] owed;
    } crd_st_t;

    crd_st_t    st_d, st_q;
    rfs_level_e lvl;

    always_comb begin
        st_d = st_q;
        unique case ({tick_i, take_i})
            2'b10: begin
                if (st_q.owed != FULL) begin
                    st_d.owed = st_q.owed + 1'b1;
                end
            end
            2'b01: begin
                if (st_q.owed != '0) begin
                    st_d.owed = st_q.owed - 1'b1;
                end
            end
            default: begin
                st_d.owed = st_q.owed;
            end
        endcase

        if (st_q.owed == '0) begin
            lvl = LVL_NONE;
        end else if (st_q.owed == FULL) begin
            lvl = LVL_URGENT;
        end else begin
            lvl = LVL_NORMAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = lvl;

endmodule

// File: rtl/rfs_rfc_timer.sv
module rfs_rfc_timer #(
    parameter int RFC_CYCLES = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int RW = $clog2(RFC_CYCLES + 1);
    localparam logic [RW-1:0] LOAD = RW'(RFC_CYCLES);

    typedef struct packed {
        logic [RW-1:0] left;
    } rfc_st_t;

    rfc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.left = LOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.left != '0);

endmodule

// File: rtl/refresh_credit_sched.sv
module refresh_credit_sched
    import rfs_pkg::*;
#(
    parameter int TICK_CYCLES = 1560,
    parameter int RFC_CYCLES  = 26,
    parameter int MAX_OWED    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic issued_i,
    output logic req_o,
    output logic urgent_o,
    output logic rfc_active_o,
    output logic err_o
);
    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t    st_d, st_q;
    logic       tick;
    logic       accept;
    logic       rfc_busy;
    rfs_level_e level;

    rfs_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rfs_credit_ctr #(.MAX_OWED(MAX_OWED)) u_crd (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .take_i  (accept),
        .level_o (level)
    );

    rfs_rfc_timer #(.RFC_CYCLES(RFC_CYCLES)) u_rfc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .active_o (rfc_busy)
    );

    always_comb begin
        st_d     = st_q;
        accept   = issued_i && (level != LVL_NONE) && !rfc_busy;
        st_d.err = issued_i && !accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign urgent_o     = (level == LVL_URGENT);
    assign req_o        = (level != LVL_NONE) && !rfc_busy && (!busy_i || urgent_o);
    assign rfc_active_o = rfc_busy;
    assign err_o        = st_q.err;

endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic issued_i,
    input logic req_o,
    input logic urgent_o,
    input logic rfc_active_o,
    input logic err_o
);
    AST_BUSY_HOLDS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !urgent_o) |-> !req_o); // R4
    AST_URGENT_FORCES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent_o && !rfc_active_o) |-> req_o); // R5
    AST_NO_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rfc_active_o |-> !req_o); // R6
    AST_ISSUE_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_i && req_o) |=> rfc_active_o); // R6
    AST_REJECT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_i && rfc_active_o) |=> err_o); // R7
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(issued_i)); // R7
    AST_ACCEPT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_i && req_o) |=> !err_o); // R7
endmodule

bind refresh_credit_sched rfs_sched_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .issued_i     (issued_i),
    .req_o        (req_o),
    .urgent_o     (urgent_o),
    .rfc_active_o (rfc_active_o),
    .err_o        (err_o)
);

// File: tb/sim_refresh_credit_sched.sv
module sim_refresh_credit_sched;
    localparam int CLK_PERIOD = 10;
    localparam int TICK = 64;
    localparam int RFC  = 5;
    localparam int MAXO = 8;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy_i = 1'b0;
    logic issued_i = 1'b0;
    logic req_o, urgent_o, rfc_active_o, err_o;

    int n_checks = 0;
    int n_fail = 0;

    // bench model state
    int  m_cnt = 0, m_owed = 0, m_rfc = 0, m_gap = 0, since_rst = 0, n_acc = 0;
    bit  m_err = 0;
    bit  gap_en = 1;
    int  cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_credit_sched #(.TICK_CYCLES(TICK), .RFC_CYCLES(RFC), .MAX_OWED(MAXO)) u0 (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .issued_i(issued_i),
        .req_o(req_o), .urgent_o(urgent_o), .rfc_active_o(rfc_active_o), .err_o(err_o)
    );

    always @(posedge clk) begin
        bit tk, acc;
        cyc = cyc + 1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            m_cnt = 0; m_owed = 0; m_rfc = 0; m_gap = 0; since_rst = 0; m_err = 0;
        end else begin
            tk  = (m_cnt == TICK - 1);
            acc = issued_i && (m_owed != 0) && (m_rfc == 0);
            m_err = issued_i && !acc;
            m_owed = m_owed + (tk ? 1 : 0) - (acc ? 1 : 0);
            if (m_owed > MAXO) m_owed = MAXO;
            m_rfc = acc ? RFC : ((m_rfc != 0) ? m_rfc - 1 : 0);
            m_cnt = tk ? 0 : m_cnt + 1;
            m_gap = acc ? 0 : m_gap + 1;
            if (acc) n_acc = n_acc + 1;
            since_rst = since_rst + 1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit e_urg, e_req;
        e_urg = (m_owed == MAXO);
        e_req = (m_owed != 0) && (m_rfc == 0) && (!busy_i || e_urg);
        check(req_o == e_req, "R4 req_o", int'(req_o), int'(e_req));
        check(urgent_o == e_urg, "R5 urgent_o", int'(urgent_o), int'(e_urg));
        check(rfc_active_o == (m_rfc != 0), "R6 rfc_active_o", int'(rfc_active_o), int'(m_rfc != 0));
        check(err_o == m_err, "R7 err_o", int'(err_o), int'(m_err));
        if (gap_en) check(m_gap <= (MAXO + 1) * TICK, "R8 refresh gap", m_gap, (MAXO + 1) * TICK);
    endtask

    // mode: 0 issue on req; 1 issue on urgent or lfsr; 2 never issue; 3 always pulse
    task automatic run(input int steps, input int mode, input int busy_mode);
        for (int i = 0; i < steps; i++) begin
            @(negedge clk);
            issued_i = 1'b0;
            case (busy_mode)
                0: busy_i = 1'b0;
                1: busy_i = 1'b1;
                default: busy_i = lfsr[3];
            endcase
            #1;
            compare_all();
            case (mode)
                0: issued_i = req_o;
                1: issued_i = req_o && (urgent_o || lfsr[7]);
                2: issued_i = 1'b0;
                default: issued_i = 1'b1;
            endcase
        end
        @(negedge clk);
        issued_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; busy_i = 1'b0; issued_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while held in reset
        check({req_o, urgent_o, rfc_active_o, err_o} == 4'b0, "R1 reset outputs",
              int'({req_o, urgent_o, rfc_active_o, err_o}), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int first;
        do_reset();
        @(negedge clk);
        #1;
        check({req_o, urgent_o, rfc_active_o, err_o} == 4'b0, "R1 first cycle after reset",
              int'({req_o, urgent_o, rfc_active_o, err_o}), 0);
        // R2: first request after exactly TICK edges
        first = -1;
        for (int i = 0; i < 2 * TICK && first < 0; i++) begin
            if (req_o) first = since_rst;
            else @(negedge clk);
        end
        check(first == TICK, "R2 first request edge", first, TICK);
        run(400, 0, 0);

        // R3: saturation at MAX_OWED, then drain exactly MAX_OWED
        do_reset();
        gap_en = 0;
        run(MAXO * TICK + TICK + 5, 2, 1);
        check(urgent_o == 1'b1, "R3 urgent after long wait", int'(urgent_o), 1);
        n_acc = 0;
        run(50, 0, 0);
        check(n_acc == MAXO, "R3 drained credits", n_acc, MAXO);
        gap_en = 1;

        // R5/R8: always busy, arbiter answers requests only (urgent ones)
        do_reset();
        run(14 * TICK, 0, 1);

        // R4/R8: random busy, lazy arbiter
        do_reset();
        run(3000, 1, 2);

        // R7: continuous pulses, many rejected
        do_reset();
        run(300, 3, 0);
        do_reset();
        run(300, 3, 2);

        summary();
        $finish;
    end
endmodule